// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Logic Unit with Packed Byte Lanes

This block is the combinational arithmetic core of a small sixteen-bit processor. A four-bit operation select, taken directly from the function field of a register-register instruction, picks one of eleven operations on two sixteen-bit operands. The result appears on the same cycle the inputs are presented.

The operations are bitwise OR and AND, wrapping add and subtract, three variable shifts whose amount comes from the second operand, and a signed less-than test. There are also three packed operations that treat each operand as two independent signed byte lanes: lane add, lane subtract and lane compare. No carry or borrow passes between the lanes.

Alongside the result, a separate flag reports whether the two operands are bit-for-bit identical, whatever the operation select. The branch logic uses this flag for its equal and not-equal decisions. Operand muxing, immediate extension and writeback sit outside this block, and it produces no carry or overflow flags.

Top module: `alu16_core`

## Requirements
- R1: Select code 0 returns A OR B and code 1 returns A AND B, bit by bit.
- R2: Select code 2 returns (A + B) mod 2^16 and code 3 returns (A - B) mod 2^16.
- R3: Select code 4 shifts A left and code 5 shifts A right, both by B[3:0] places, filling vacated bits with zero.
- R4: Select code 6 shifts A right by B[3:0] places, filling vacated high bits with a copy of A[15].
- R5: Select code 7 returns 16'h0001 when A is less than B as signed two's complement values, and 16'h0000 otherwise.
- R6: Select code 8 returns {A[15:8]+B[15:8], A[7:0]+B[7:0]}, each lane mod 2^8, with no carry from bit 7 into bit 8.
- R7: Select code 9 returns {A[15:8]-B[15:8], A[7:0]-B[7:0]}, each lane mod 2^8, with no borrow from bit 8 into bit 7.
- R8: Select code 10 sets result bit 8 when A[15:8] < B[15:8] and bit 0 when A[7:0] < B[7:0], both as signed bytes; all other result bits are zero.
- R9: Select codes 11 to 15 return 16'h0000.
- R10: The equality output is 1 exactly when A equals B, independent of the select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select (codes as listed in the requirements) |
| opnd_a | input | 16 | First operand; the value shifted by the shift operations |
| opnd_b | input | 16 | Second operand; its low four bits give the shift amount |
| result | output | 16 | Operation result |
| operands_equal | output | 1 | High when both operands are identical |

## Verification
The immediate checks inside the RTL assume that all three inputs settle together before the logic is evaluated. The sum, difference and shift relations they check are only meaningful on settled values. The bench therefore changes op_sel, opnd_a and opnd_b together, just after a rising edge, and compares at the following falling edge. It draws shift amounts from 0 to 15 only, because amounts beyond that range have no defined result. The directed vectors cover lane carry and borrow boundaries, signed byte comparisons across the sign boundary, full-width shifts and unused select codes. A seeded random sweep then compares every operation with an arithmetic model written independently in the bench.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_OR   = 4'd0,
    OP_AND  = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd3,
    OP_SHL  = 4'd4,
    OP_SHR  = 4'd5,
    OP_SHRA = 4'd6,
    OP_SLT  = 4'd7,
    OP_LADD = 4'd8,
    OP_LSUB = 4'd9,
    OP_LSLT = 4'd10
  } alu_op_e;

endpackage

// File: rtl/alu16_bitwise_shift.sv
module alu16_bitwise_shift #(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SHW-1:0]   amt_i,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] shl_o,
  output logic [WIDTH-1:0] shr_o,
  output logic [WIDTH-1:0] shra_o
);

  always_comb begin
    or_o   = a_i | b_i;
    and_o  = a_i & b_i;
    shl_o  = a_i << amt_i;
    shr_o  = a_i >> amt_i;
    shra_o = WIDTH'($signed(a_i) >>> amt_i);
  end

  // Vacated bits after a nonzero shift are zero (R3); arithmetic shift keeps the sign (R4).
  always_comb begin
    p_shl_zero_fill_r3: assert ((amt_i == '0) || (shl_o[0] == 1'b0))
      else $error("left shift did not zero-fill bit 0");
    p_shr_zero_fill_r3: assert ((amt_i == '0) || (shr_o[WIDTH-1] == 1'b0))
      else $error("logical right shift did not zero-fill the top bit");
    p_shra_sign_fill_r4: assert (shra_o[WIDTH-1] == a_i[WIDTH-1])
      else $error("arithmetic right shift lost the sign bit");
  end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] diff_o,
  output logic             lt_o
);

  always_comb begin
    sum_o  = a_i + b_i;
    diff_o = a_i - b_i;
    lt_o   = $signed(a_i) < $signed(b_i);
  end

  logic [WIDTH-1:0] sum_back;
  logic [WIDTH-1:0] diff_back;

  always_comb begin
    sum_back  = sum_o - b_i;
    diff_back = diff_o + b_i;
    p_add_inverse_r2: assert (sum_back == a_i)
      else $error("sum minus B does not recover A");
    p_sub_inverse_r2: assert (diff_back == a_i)
      else $error("difference plus B does not recover A");
    p_slt_irreflexive_r5: assert (!((a_i == b_i) && lt_o))
      else $error("less-than reported for equal operands");
  end

endmodule

// File: rtl/alu16_lanes.sv
module alu16_lanes #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = WIDTH / LANE_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] lsum_o,
  output logic [WIDTH-1:0] ldiff_o,
  output logic [WIDTH-1:0] llt_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la;
    logic [LANE_W-1:0] lb;
    logic [LANE_W-1:0] sum_back;
    logic [LANE_W-1:0] diff_back;

    assign la = a_i[g*LANE_W +: LANE_W];
    assign lb = b_i[g*LANE_W +: LANE_W];

    always_comb begin
      lsum_o[g*LANE_W +: LANE_W]          = la + lb;
      ldiff_o[g*LANE_W +: LANE_W]         = la - lb;
      llt_o[g*LANE_W]                     = $signed(la) < $signed(lb);
      llt_o[g*LANE_W+1 +: LANE_W-1]       = '0;
    end

    // Each lane must invert on its own: no carry or borrow from a neighbour (R6, R7).
    always_comb begin
      sum_back  = lsum_o[g*LANE_W +: LANE_W] - lb;
      diff_back = ldiff_o[g*LANE_W +: LANE_W] + lb;
      p_lane_add_isolated_r6: assert (sum_back == la)
        else $error("lane %0d sum disturbed by another lane", g);
      p_lane_sub_isolated_r7: assert (diff_back == la)
        else $error("lane %0d difference disturbed by another lane", g);
      p_lane_lt_irreflexive_r8: assert (!((la == lb) && llt_o[g*LANE_W]))
        else $error("lane %0d less-than set for equal bytes", g);
    end
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int unsigned WIDTH  = DATA_W,
  parameter int unsigned LANE_W = alu16_pkg::LANE_W,
  localparam int unsigned SHW   = $clog2(WIDTH)
) (
  input  logic [SEL_W-1:0] op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             operands_equal
);

  logic [WIDTH-1:0] or_v, and_v, shl_v, shr_v, shra_v;
  logic [WIDTH-1:0] sum_v, diff_v;
  logic             lt_v;
  logic [WIDTH-1:0] lsum_v, ldiff_v, llt_v;

  alu16_bitwise_shift #(.WIDTH(WIDTH)) u_bitshift (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .amt_i  (opnd_b[SHW-1:0]),
    .or_o   (or_v),
    .and_o  (and_v),
    .shl_o  (shl_v),
    .shr_o  (shr_v),
    .shra_o (shra_v)
  );

  alu16_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .sum_o  (sum_v),
    .diff_o (diff_v),
    .lt_o   (lt_v)
  );

  alu16_lanes #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_lanes (
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .lsum_o  (lsum_v),
    .ldiff_o (ldiff_v),
    .llt_o   (llt_v)
  );

  always_comb begin
    unique case (op_sel)
      OP_OR:   result = or_v;
      OP_AND:  result = and_v;
      OP_ADD:  result = sum_v;
      OP_SUB:  result = diff_v;
      OP_SHL:  result = shl_v;
      OP_SHR:  result = shr_v;
      OP_SHRA: result = shra_v;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_v};
      OP_LADD: result = lsum_v;
      OP_LSUB: result = ldiff_v;
      OP_LSLT: result = llt_v;
      default: result = '0;
    endcase
  end

  assign operands_equal = (opnd_a == opnd_b);

  always_comb begin
    p_eq_vs_diff_r10: assert (operands_equal == (diff_v == '0))
      else $error("equality flag disagrees with the subtractor");
    p_unused_zero_r9: assert ((op_sel <= SEL_W'(OP_LSLT)) || (result == '0))
      else $error("unused select code produced a nonzero result");
    p_slt_boolean_r5: assert ((op_sel != SEL_W'(OP_SLT)) || (result[WIDTH-1:1] == '0))
      else $error("set-less-than produced bits above bit 0");
  end

endmodule

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;

  logic clk;
  logic rst_n;
  logic [3:0]  op_sel;
  logic [15:0] opnd_a;
  logic [15:0] opnd_b;
  logic [15:0] result;
  logic        operands_equal;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic        eq;
    string       tag;
  } item_t;

  item_t sb_q[$];

  alu16_core dut_i (
    .op_sel         (op_sel),
    .opnd_a         (opnd_a),
    .opnd_b         (opnd_b),
    .result         (result),
    .operands_equal (operands_equal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] model(input logic [3:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    int sa, sb, hi, lo, k;
    logic [15:0] r;
    k = int'(b[3:0]);
    r = 16'h0000;
    case (op)
      4'd0: for (int i = 0; i < 16; i++) r[i] = a[i] | b[i];
      4'd1: for (int i = 0; i < 16; i++) r[i] = a[i] & b[i];
      4'd2: r = 16'((int'(a) + int'(b)) % 65536);
      4'd3: r = 16'((int'(a) - int'(b) + 65536) % 65536);
      4'd4: for (int i = 0; i < 16; i++) r[i] = (i >= k) ? a[i-k] : 1'b0;
      4'd5: for (int i = 0; i < 16; i++) r[i] = (i + k <= 15) ? a[i+k] : 1'b0;
      4'd6: for (int i = 0; i < 16; i++) r[i] = (i + k <= 15) ? a[i+k] : a[15];
      4'd7: begin
        sa = a[15] ? int'(a) - 65536 : int'(a);
        sb = b[15] ? int'(b) - 65536 : int'(b);
        r = (sa < sb) ? 16'd1 : 16'd0;
      end
      4'd8: begin
        hi = (int'(a[15:8]) + int'(b[15:8])) % 256;
        lo = (int'(a[7:0]) + int'(b[7:0])) % 256;
        r = 16'(hi * 256 + lo);
      end
      4'd9: begin
        hi = (int'(a[15:8]) - int'(b[15:8]) + 256) % 256;
        lo = (int'(a[7:0]) - int'(b[7:0]) + 256) % 256;
        r = 16'(hi * 256 + lo);
      end
      4'd10: begin
        sa = a[15] ? int'(a[15:8]) - 256 : int'(a[15:8]);
        sb = b[15] ? int'(b[15:8]) - 256 : int'(b[15:8]);
        r[8] = (sa < sb);
        sa = a[7] ? int'(a[7:0]) - 256 : int'(a[7:0]);
        sb = b[7] ? int'(b[7:0]) - 256 : int'(b[7:0]);
        r[0] = (sa < sb);
      end
      default: r = 16'h0000;
    endcase
    return r;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] exp_res, input logic exp_eq, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    op_sel = op;
    opnd_a = a;
    opnd_b = b;
    it.op = op; it.a = a; it.b = b; it.res = exp_res; it.eq = exp_eq; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare at the falling edge, half a cycle after the inputs changed.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (result !== it.res || operands_equal !== it.eq) begin
          n_errors++;
          $display("FAIL %s op=%0d a=%h b=%h actual res=%h eq=%b expected res=%h eq=%b",
                   it.tag, it.op, it.a, it.b, result, operands_equal, it.res, it.eq);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    op_sel = 4'd0; opnd_a = 16'h0000; opnd_b = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // State after reset with all-zero inputs (R1, R10)
    drive(4'd0, 16'h0000, 16'h0000, 16'h0000, 1'b1, "R1 reset idle");
    // R1
    drive(4'd0, 16'hF0F0, 16'h0FF0, 16'hFFF0, 1'b0, "R1 or");
    drive(4'd1, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b0, "R1 and");
    // R2
    drive(4'd2, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, "R2 add wrap");
    drive(4'd3, 16'h0000, 16'h0001, 16'hFFFF, 1'b0, "R2 sub wrap");
    // R3
    drive(4'd4, 16'h8001, 16'h0001, 16'h0002, 1'b0, "R3 shl by 1");
    drive(4'd4, 16'h0001, 16'h000F, 16'h8000, 1'b0, "R3 shl by 15");
    drive(4'd5, 16'h8000, 16'h000F, 16'h0001, 1'b0, "R3 shr by 15");
    drive(4'd5, 16'hABCD, 16'h0000, 16'hABCD, 1'b0, "R3 shr by 0");
    // R4
    drive(4'd6, 16'h8000, 16'h0004, 16'hF800, 1'b0, "R4 shra negative");
    drive(4'd6, 16'h4000, 16'h0004, 16'h0400, 1'b0, "R4 shra positive");
    // R5
    drive(4'd7, 16'hFFFF, 16'h0001, 16'h0001, 1'b0, "R5 slt -1<1");
    drive(4'd7, 16'h0001, 16'hFFFF, 16'h0000, 1'b0, "R5 slt 1<-1");
    drive(4'd7, 16'h8000, 16'h8000, 16'h0000, 1'b1, "R5 slt equal");
    // R6
    drive(4'd8, 16'h01FF, 16'h0001, 16'h0100, 1'b0, "R6 ladd no carry into upper");
    drive(4'd8, 16'h80FF, 16'h8001, 16'h0000, 1'b0, "R6 ladd both lanes wrap");
    // R7
    drive(4'd9, 16'h0100, 16'h0001, 16'h01FF, 1'b0, "R7 lsub no borrow from upper");
    drive(4'd9, 16'h0000, 16'h0101, 16'hFFFF, 1'b0, "R7 lsub both lanes wrap");
    // R8
    drive(4'd10, 16'h807F, 16'h0180, 16'h0100, 1'b0, "R8 lslt upper only");
    drive(4'd10, 16'h0580, 16'h0501, 16'h0001, 1'b0, "R8 lslt lower only");
    drive(4'd10, 16'hFFFF, 16'h0000, 16'h0101, 1'b0, "R8 lslt both");
    // R9
    drive(4'd11, 16'hFFFF, 16'h1234, 16'h0000, 1'b0, "R9 code 11");
    drive(4'd15, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, "R9 code 15");
    // R10
    drive(4'd0, 16'h1234, 16'h1234, 16'h1234, 1'b1, "R10 equal under or");
    drive(4'd2, 16'h1234, 16'h1235, 16'h2469, 1'b0, "R10 differ by one bit");

    // Random sweep against the bench model (R1 to R10)
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  op;
      logic [15:0] a, b;
      op = 4'($urandom_range(0, 15));
      a  = 16'($urandom());
      b  = (n % 8 == 0) ? a : 16'($urandom());
      if (op >= 4'd4 && op <= 4'd6) b = {12'h000, b[3:0]};
      drive(op, a, b, model(op, a, b), (a == b), "R1-R10 sweep model");
    end

    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule